// File: doc/BRIEF.md
# Root Port Interrupt Router

This block sits beside one PCI Express root port. It decides whether each status event becomes a message-signaled interrupt (MSI) request, a system-level error pulse (of the NMI/SMI/MCA kind), both of these, or neither. There are two families of event. The first is link events: a change in link bandwidth and a link-management change. The second is error events, sorted into fatal, non-fatal and corrected classes. Each event input is a level that a status register drives. The block acts on the rising edge of that level, so a status bit that stays set yields one event only.

Six control bits select the routing. They are MSI enable, a mask that keeps link events from raising MSI, and a mask that keeps error events from raising MSI. The other three are one system-error enable for each error class. The controls are registered inside the block and cleared by reset. Every output is a registered pulse that lasts one clock. An event that arrives while its path is masked or disabled is discarded. It is never replayed when the path opens later.

Top module: `rp_irq_route`

## Requirements
- R1: While `rst_n` is low all outputs are 0 and the registered controls and edge history clear to 0. As a result, an event that is seen at the first edge after reset release produces no output, even when the control inputs are already high.
- R2: A rising edge on `lnk_bw_chg` or `lnk_mgmt_chg` with MSI enabled and the link mask clear raises `msi_req` for exactly one cycle. The pulse appears one clock after the edge at which the new level is first sampled.
- R3: With `lnk_msi_mask` set, link events raise no `msi_req`. Error events are still routed to MSI.
- R4: With `err_msi_mask` set, error events never raise `msi_req`, whatever the value of `msi_en`. With the mask clear and `msi_en` set, each error event raises `msi_req`. The error mask does not affect link events.
- R5: With `msi_en` clear, no event raises `msi_req`.
- R6: A rising edge on `err_fatal`, `err_nonfatal` or `err_corr` raises `serr_fatal`, `serr_nonfatal` or `serr_corr` respectively, but only when that class's own enable is set. This routing does not depend on `msi_en` or `err_msi_mask`. Link events never raise a system error.
- R7: One error event can raise `msi_req` and its system-error pulse in the same cycle.
- R8: When several events rise in the same cycle, they produce a single one-cycle `msi_req` pulse.
- R9: A level held high produces only one pulse per output. An event dropped because its path was masked is not delivered when the mask is later cleared while the level stays high.
- R10: A change on a control input takes effect one clock later. An event that is first sampled at the same edge as the control change is routed using the old control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_en | input | 1 | MSI enable |
| lnk_msi_mask | input | 1 | Block MSI for link events |
| err_msi_mask | input | 1 | Block MSI for error events |
| serr_fatal_en | input | 1 | System error enable, fatal class |
| serr_nonfatal_en | input | 1 | System error enable, non-fatal class |
| serr_corr_en | input | 1 | System error enable, corrected class |
| lnk_bw_chg | input | 1 | Link bandwidth change status level |
| lnk_mgmt_chg | input | 1 | Link management change status level |
| err_fatal | input | 1 | Fatal error status level |
| err_nonfatal | input | 1 | Non-fatal error status level |
| err_corr | input | 1 | Corrected error status level |
| msi_req | output | 1 | One-cycle MSI request pulse |
| serr_fatal | output | 1 | One-cycle fatal system error pulse |
| serr_nonfatal | output | 1 | One-cycle non-fatal system error pulse |
| serr_corr | output | 1 | One-cycle corrected system error pulse |

## Verification
Two functions can fall in the same cycle: the MSI request and a class's system-error pulse, both triggered by a single error edge. Vectors that enable MSI together with one system-error enable per class raise that class alone. Each such vector expects both outputs high at the same sample and both low one cycle later. A further vector keeps MSI masked for errors while the system-error enables stay set, which shows that the two paths separate cleanly.

// File: rtl/rp_irq_route.sv
module rp_irq_route (
  input  logic clk,
  input  logic rst_n,
  input  logic msi_en,
  input  logic lnk_msi_mask,
  input  logic err_msi_mask,
  input  logic serr_fatal_en,
  input  logic serr_nonfatal_en,
  input  logic serr_corr_en,
  input  logic lnk_bw_chg,
  input  logic lnk_mgmt_chg,
  input  logic err_fatal,
  input  logic err_nonfatal,
  input  logic err_corr,
  output logic msi_req,
  output logic serr_fatal,
  output logic serr_nonfatal,
  output logic serr_corr
);

  logic       en_q, lmask_q, emask_q;
  logic [2:0] sen_q;
  logic [1:0] lnk_q;
  logic [2:0] err_q;

  logic [1:0] lnk_now;
  logic [2:0] err_now;
  logic [1:0] lnk_rise;
  logic [2:0] err_rise;
  logic       lnk_msi, err_msi;

  assign lnk_now  = {lnk_bw_chg, lnk_mgmt_chg};
  assign err_now  = {err_fatal, err_nonfatal, err_corr};
  assign lnk_rise = lnk_now & ~lnk_q;
  assign err_rise = err_now & ~err_q;

  assign lnk_msi = (|lnk_rise) & ~lmask_q;
  assign err_msi = (|err_rise) & ~emask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q          <= 1'b0;
      lmask_q       <= 1'b0;
      emask_q       <= 1'b0;
      sen_q         <= '0;
      lnk_q         <= '0;
      err_q         <= '0;
      msi_req       <= 1'b0;
      serr_fatal    <= 1'b0;
      serr_nonfatal <= 1'b0;
      serr_corr     <= 1'b0;
    end else begin
      en_q          <= msi_en;
      lmask_q       <= lnk_msi_mask;
      emask_q       <= err_msi_mask;
      sen_q         <= {serr_fatal_en, serr_nonfatal_en, serr_corr_en};
      lnk_q         <= lnk_now;
      err_q         <= err_now;
      msi_req       <= en_q & (lnk_msi | err_msi);
      serr_fatal    <= err_rise[2] & sen_q[2];
      serr_nonfatal <= err_rise[1] & sen_q[1];
      serr_corr     <= err_rise[0] & sen_q[0];
    end
  end

  // R1: reset clears every output
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !msi_req && !serr_fatal && !serr_nonfatal && !serr_corr);

  // R5: MSI only while enable was registered high
  p_msi_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(en_q));

  // R3: masked link path means an error edge caused the MSI
  p_lnk_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req && $past(lmask_q)) |-> $past(|err_rise));

  // R4: masked error path means a link edge caused the MSI
  p_err_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req && $past(emask_q)) |-> $past(|lnk_rise));

  // R6: each system error needs its own enable and an edge of its class
  p_serr_fatal_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_fatal |-> $past(sen_q[2]) && $past(err_fatal));
  p_serr_nonfatal_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_nonfatal |-> $past(sen_q[1]) && $past(err_nonfatal));
  p_serr_corr_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_corr |-> $past(sen_q[0]) && $past(err_corr));

  // R9: one pulse per edge, never two in a row
  p_fatal_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_fatal |=> !serr_fatal);
  p_nonfatal_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_nonfatal |=> !serr_nonfatal);
  p_corr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_corr |=> !serr_corr);

endmodule

// File: tb/sim_rp_irq_route.sv
module sim_rp_irq_route;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ctl = '0;
  logic [4:0] ev  = '0;
  logic msi_req, serr_fatal, serr_nonfatal, serr_corr;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rp_irq_route u0 (
    .clk(clk), .rst_n(rst_n),
    .msi_en(ctl[5]), .lnk_msi_mask(ctl[4]), .err_msi_mask(ctl[3]),
    .serr_fatal_en(ctl[2]), .serr_nonfatal_en(ctl[1]), .serr_corr_en(ctl[0]),
    .lnk_bw_chg(ev[4]), .lnk_mgmt_chg(ev[3]),
    .err_fatal(ev[2]), .err_nonfatal(ev[1]), .err_corr(ev[0]),
    .msi_req(msi_req), .serr_fatal(serr_fatal),
    .serr_nonfatal(serr_nonfatal), .serr_corr(serr_corr)
  );

  // {ctl: en lmask emask fen nfen cen, ev: bw mgmt fat nf cor, exp: msi sf snf sc}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {6'b100000, 5'b10000, 4'b1000},  // R2 bandwidth
    {6'b100000, 5'b01000, 4'b1000},  // R2 management
    {6'b110000, 5'b11000, 4'b0000},  // R3 link masked
    {6'b110000, 5'b00100, 4'b1000},  // R3 errors unaffected
    {6'b101000, 5'b00111, 4'b0000},  // R4 errors masked
    {6'b101000, 5'b10000, 4'b1000},  // R4 link unaffected
    {6'b001111, 5'b00111, 4'b0111},  // R6 serr despite mask
    {6'b000100, 5'b00100, 4'b0100},  // R6 no msi_en
    {6'b000000, 5'b11111, 4'b0000},  // R5 nothing enabled
    {6'b100100, 5'b00100, 4'b1100},  // R7 fatal both
    {6'b100010, 5'b00010, 4'b1010},  // R7 nonfatal both
    {6'b100001, 5'b00001, 4'b1001},  // R7 corrected both
    {6'b100000, 5'b11111, 4'b1000},  // R8 many edges one pulse
    {6'b000011, 5'b00111, 4'b0011}   // R6 fatal enable off
  };

  function automatic string vtag(int i);
    case (i)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6, 7, 13: return "R6";
      8: return "R5";
      9, 10, 11: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [3:0] outs();
    return {msi_req, serr_fatal, serr_nonfatal, serr_corr};
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int cnt_m, cnt_f;
    // R1: outputs held low in reset even with everything driven
    @(negedge clk); ctl = 6'b111111 & 6'b100111; ev = 5'b11111;
    @(negedge clk); check("R1 in reset", outs(), 4'b0000);
    ev = 5'b00000;
    @(negedge clk); ev = 5'b10111;
    @(negedge clk); check("R1 in reset toggled", outs(), 4'b0000);
    rst_n = 1'b1;  // first edge sees rise but controls still cleared
    @(negedge clk); check("R1 first cycle after reset", outs(), 4'b0000);
    @(negedge clk); check("R1 held level dropped", outs(), 4'b0000);
    ev = '0; ctl = '0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ctl = VEC[i][14:9]; ev = '0;
      @(negedge clk); ev = VEC[i][8:4];
      @(negedge clk); check({vtag(i), " vector"}, outs(), VEC[i][3:0]);
      ev = '0;
      @(negedge clk); check({vtag(i), " pulse ends"}, outs(), 4'b0000);
    end

    // R9: held level gives exactly one pulse
    ctl = 6'b100100; ev = '0;
    @(negedge clk); ev = 5'b00100;
    cnt_m = 0; cnt_f = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); cnt_m += int'(msi_req); cnt_f += int'(serr_fatal);
    end
    check("R9 held msi count", 4'(cnt_m), 4'd1);
    check("R9 held serr count", 4'(cnt_f), 4'd1);
    ev = '0;
    @(negedge clk);

    // R9: masked event not replayed when mask clears
    ctl = 6'b101000;
    @(negedge clk); ev = 5'b00010;
    @(negedge clk); check("R9 masked drop", outs(), 4'b0000);
    ctl = 6'b100000;
    cnt_m = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); cnt_m += int'(msi_req);
    end
    check("R9 no replay after unmask", 4'(cnt_m), 4'd0);
    ev = '0; ctl = '0;
    @(negedge clk);

    // R10: control change at same edge as event uses old value
    @(negedge clk); ctl = 6'b100100; ev = 5'b10100;
    @(negedge clk); check("R10 old controls used", outs(), 4'b0000);
    ev = '0;
    @(negedge clk); ev = 5'b00100;
    @(negedge clk); check("R10 new controls active", outs(), 4'b1100);
    ev = '0;
    // R10: disabling at same edge as event still delivers
    @(negedge clk); ctl = '0; ev = 5'b00100;
    @(negedge clk); check("R10 old enable still routes", outs(), 4'b1100);
    ev = '0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule